// File: doc/BRIEF.md
# Black-Level Digital Clamp Controller

This block sits behind a video digitizer that converts luma on its own path and converts the two colour-difference channels U and V on one shared path, one channel per clock. It compares the digitized codes with fixed black-level targets. While an external clamp window is open, it issues up and down commands to the analog charge pumps that set each channel's black level. Luma is steered to code 16, and both chroma channels are steered to code 128.

A window must stay open for a minimum number of consecutive clocks before any command is issued. This rejects short glitches on the window input. A free-running select bit, which starts on U after reset, decides whether the shared chroma code belongs to U or to V on each clock. Only the selected chroma channel can receive a command on that clock.

For the first few qualified windows after reset, every command carries a coarse-step flag so that the clamp capacitors charge quickly. After those windows, commands are single fine steps. A chroma-invalid flag tells downstream logic that chroma samples taken during the window are not picture data.

Top module: `blk_level_clamp`

## Requirements
- R1: During a qualified window, `y_up` is high when the luma code is below 16, `y_dn` is high when it is above 16, and neither is high when it equals 16. These outputs appear one clock after the code is sampled.
- R2: During a qualified window, the selected chroma channel's up output is high when the chroma code is below 128, and its down output is high when the code is above 128. Neither is high when the code equals 128. These outputs also appear one clock after sampling.
- R3: A clock sampled with `clamp_win` low yields every up, down and step output low on the next clock.
- R4: Correction is enabled only from the MIN_WIN-th (default 20th) consecutive clock with `clamp_win` high. A window shorter than MIN_WIN clocks produces no command at all.
- R5: The chroma select alternates on every clock. The first clock after reset is a U clock, the second is a V clock, and so on. U outputs are driven only from U clocks and V outputs only from V clocks.
- R6: `chroma_bad` is high exactly one clock after each clock sampled with `clamp_win` high.
- R7: A window counts once it has reached qualification and then closes. While fewer than PRE_WINS (default 8) windows have counted since reset, each non-zero command also raises its channel's `*_big` step flag. From then on, every `*_big` flag stays low.
- R8: While `rst_n` is low, and on the first clock after it rises, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clamp_win | input | 1 | Clamp window request |
| luma_code | input | 8 | Digitized luma code |
| chroma_code | input | 8 | Digitized chroma code, U and V alternating |
| y_up | output | 1 | Raise luma black level |
| y_dn | output | 1 | Lower luma black level |
| y_big | output | 1 | Luma command is a coarse step |
| u_up | output | 1 | Raise U black level |
| u_dn | output | 1 | Lower U black level |
| u_big | output | 1 | U command is a coarse step |
| v_up | output | 1 | Raise V black level |
| v_dn | output | 1 | Lower V black level |
| v_big | output | 1 | V command is a coarse step |
| chroma_bad | output | 1 | Chroma samples are invalid (window open) |

## Verification
Two events can fall in the same clock. The first is the window closing, which advances the precharge window count. The second is the clock on which a command would otherwise still carry a coarse flag. The bench provokes this by running back-to-back windows of different lengths, including one that is exactly MIN_WIN clocks long, across the eighth counted window. The reference model then decides whether the ninth window is fine in every cycle. The chroma select toggle and window qualification also coincide on the 20th clock. Windows are therefore started on both even and odd phases, so that the first command lands on U in some windows and on V in others.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   localparam int unsigned CH_COUNT = 3;
   typedef enum logic [1:0] {CH_Y = 2'd0, CH_U = 2'd1, CH_V = 2'd2} chan_e;
   typedef struct packed {
      logic up;
      logic dn;
      logic big;
   } cmd_t;
endpackage

// File: rtl/clamp_win_qual.sv
module clamp_win_qual #(
   parameter int unsigned MIN_WIN = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win,
   output logic qual,
   output logic win_done
);
   localparam int unsigned CW = $clog2(MIN_WIN + 1);
   localparam logic [CW-1:0] FULL = CW'(MIN_WIN);
   localparam logic [CW-1:0] LAST = CW'(MIN_WIN - 1);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!win)
         run_q <= '0;
      else if (run_q != FULL)
         run_q <= run_q + 1'b1;
   end

   assign qual     = win && (run_q >= LAST);
   assign win_done = !win && (run_q == FULL);

   // R4: qualification needs a preceding high clock unless MIN_WIN is one
   assert_qual_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      qual && (MIN_WIN > 1) |-> $past(win));
endmodule

// File: rtl/clamp_precharge.sv
module clamp_precharge #(
   parameter int unsigned PRE_WINS = 8,
   parameter bit          PRE_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_done,
   output logic pre_active
);
   generate
      if (PRE_EN && PRE_WINS > 0) begin : g_pre
         localparam int unsigned PW = $clog2(PRE_WINS + 1);
         localparam logic [PW-1:0] LIM = PW'(PRE_WINS);
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (win_done && cnt_q != LIM)
               cnt_q <= cnt_q + 1'b1;
         end
         assign pre_active = (cnt_q != LIM);
      end else begin : g_nopre
         assign pre_active = 1'b0;
      end
   endgenerate

   // R7: once precharge has ended it never returns before reset
   assert_pre_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_active |=> !pre_active);
endmodule

// File: rtl/clamp_chan.sv
module clamp_chan
   import clamp_pkg::*;
#(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned TARGET = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pre,
   input  logic [CODE_W-1:0] code,
   output cmd_t              cmd
);
   localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET);

   logic below, above;
   assign below = code < TGT;
   assign above = code > TGT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= '0;
      end else begin
         cmd.up  <= en && below;
         cmd.dn  <= en && above;
         cmd.big <= en && pre && (below || above);
      end
   end

   // R1/R2: a command never raises and lowers at once
   assert_up_dn_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd.up && cmd.dn));
   // R7: the coarse flag only accompanies a real command
   assert_big_with_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.big |-> (cmd.up || cmd.dn));
endmodule

// File: rtl/blk_level_clamp.sv
module blk_level_clamp
   import clamp_pkg::*;
#(
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned Y_TARGET = 16,
   parameter int unsigned C_TARGET = 128,
   parameter int unsigned MIN_WIN  = 20,
   parameter int unsigned PRE_WINS = 8,
   parameter bit          PRE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clamp_win,
   input  logic [CODE_W-1:0] luma_code,
   input  logic [CODE_W-1:0] chroma_code,
   output logic              y_up,
   output logic              y_dn,
   output logic              y_big,
   output logic              u_up,
   output logic              u_dn,
   output logic              u_big,
   output logic              v_up,
   output logic              v_dn,
   output logic              v_big,
   output logic              chroma_bad
);
   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_w
         $error("CODE_W out of range");
      end
      if (Y_TARGET > CODE_MAX || C_TARGET > CODE_MAX) begin : g_bad_tgt
         $error("target code exceeds code range");
      end
      if (MIN_WIN < 1) begin : g_bad_win
         $error("MIN_WIN must be at least one");
      end
   endgenerate

   logic qual, win_done, pre_active, sel_v, bad_q;
   logic [CH_COUNT-1:0] ch_en;
   logic [CODE_W-1:0]   ch_code [CH_COUNT];
   cmd_t                ch_cmd  [CH_COUNT];

   clamp_win_qual #(.MIN_WIN(MIN_WIN)) i_qual (
      .clk(clk), .rst_n(rst_n), .win(clamp_win),
      .qual(qual), .win_done(win_done));

   clamp_precharge #(.PRE_WINS(PRE_WINS), .PRE_EN(PRE_EN)) i_pre (
      .clk(clk), .rst_n(rst_n), .win_done(win_done), .pre_active(pre_active));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_v <= 1'b0;
         bad_q <= 1'b0;
      end else begin
         sel_v <= ~sel_v;
         bad_q <= clamp_win;
      end
   end

   assign ch_en[CH_Y]   = qual;
   assign ch_en[CH_U]   = qual && !sel_v;
   assign ch_en[CH_V]   = qual && sel_v;
   assign ch_code[CH_Y] = luma_code;
   assign ch_code[CH_U] = chroma_code;
   assign ch_code[CH_V] = chroma_code;

   genvar gi;
   generate
      for (gi = 0; gi < CH_COUNT; gi++) begin : g_ch
         localparam int unsigned TGT = (gi == CH_Y) ? Y_TARGET : C_TARGET;
         clamp_chan #(.CODE_W(CODE_W), .TARGET(TGT)) i_chan (
            .clk(clk), .rst_n(rst_n), .en(ch_en[gi]), .pre(pre_active),
            .code(ch_code[gi]), .cmd(ch_cmd[gi]));
      end
   endgenerate

   assign y_up  = ch_cmd[CH_Y].up;
   assign y_dn  = ch_cmd[CH_Y].dn;
   assign y_big = ch_cmd[CH_Y].big;
   assign u_up  = ch_cmd[CH_U].up;
   assign u_dn  = ch_cmd[CH_U].dn;
   assign u_big = ch_cmd[CH_U].big;
   assign v_up  = ch_cmd[CH_V].up;
   assign v_dn  = ch_cmd[CH_V].dn;
   assign v_big = ch_cmd[CH_V].big;
   assign chroma_bad = bad_q;

   // R3: nothing moves after a clock with the window closed
   assert_idle_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clamp_win |=> !(y_up || y_dn || u_up || u_dn || v_up || v_dn ||
                       y_big || u_big || v_big));
   // R5: U and V never receive commands in the same clock
   assert_one_chroma_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !((u_up || u_dn) && (v_up || v_dn)));
   // R5: chroma commands alternate channels on consecutive clocks
   assert_alt_chroma_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (u_up || u_dn) |=> !(u_up || u_dn));
   // R6: open window flags chroma invalid on the next clock
   assert_bad_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_win |=> chroma_bad);
endmodule

// File: tb/test_blk_level_clamp.sv
`timescale 1ns/100ps
module test_blk_level_clamp;
   localparam int MIN_WIN = 20;
   localparam int PRE_WINS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clamp_win = 1'b0;
   logic [7:0] luma_code = '0;
   logic [7:0] chroma_code = '0;
   logic y_up, y_dn, y_big, u_up, u_dn, u_big, v_up, v_dn, v_big, chroma_bad;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int run = 0;
   int pre = 0;
   int phase = 0;
   bit e_yu, e_yd, e_yb, e_uu, e_ud, e_ub, e_vu, e_vd, e_vb, e_bad;
   int moves = 0;

   always #2.5 clk = ~clk;

   blk_level_clamp i_blk_level_clamp (
      .clk(clk), .rst_n(rst_n), .clamp_win(clamp_win),
      .luma_code(luma_code), .chroma_code(chroma_code),
      .y_up(y_up), .y_dn(y_dn), .y_big(y_big),
      .u_up(u_up), .u_dn(u_dn), .u_big(u_big),
      .v_up(v_up), .v_dn(v_dn), .v_big(v_big),
      .chroma_bad(chroma_bad));

   task automatic check(input string tag, input string name, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit w, input int y, input int c);
      bit qual, cu, cv;
      clamp_win = w;
      luma_code = 8'(y);
      chroma_code = 8'(c);
      qual = w && (run >= MIN_WIN - 1);
      cu = qual && (phase % 2 == 0);
      cv = qual && (phase % 2 == 1);
      e_yu = qual && (y < 16);
      e_yd = qual && (y > 16);
      e_yb = qual && (pre < PRE_WINS) && (y != 16);
      e_uu = cu && (c < 128);
      e_ud = cu && (c > 128);
      e_ub = cu && (pre < PRE_WINS) && (c != 128);
      e_vu = cv && (c < 128);
      e_vd = cv && (c > 128);
      e_vb = cv && (pre < PRE_WINS) && (c != 128);
      e_bad = w;
      if (w) run++;
      else begin
         if (run >= MIN_WIN && pre < PRE_WINS) pre++;
         run = 0;
      end
      phase++;
      @(posedge clk);
      @(negedge clk);
      check("R1", "y_up", y_up, e_yu);
      check("R1", "y_dn", y_dn, e_yd);
      check("R2", "u_up", u_up, e_uu);
      check("R2", "u_dn", u_dn, e_ud);
      check("R5", "v_up", v_up, e_vu);
      check("R5", "v_dn", v_dn, e_vd);
      check("R7", "y_big", y_big, e_yb);
      check("R7", "u_big", u_big, e_ub);
      check("R7", "v_big", v_big, e_vb);
      check("R6", "chroma_bad", chroma_bad, e_bad);
      if (y_up || y_dn || u_up || u_dn || v_up || v_dn) moves++;
   endtask

   task automatic all_low(input string tag);
      check(tag, "y_up", y_up, 1'b0);   check(tag, "y_dn", y_dn, 1'b0);
      check(tag, "u_up", u_up, 1'b0);   check(tag, "u_dn", u_dn, 1'b0);
      check(tag, "v_up", v_up, 1'b0);   check(tag, "v_dn", v_dn, 1'b0);
      check(tag, "y_big", y_big, 1'b0); check(tag, "u_big", u_big, 1'b0);
      check(tag, "v_big", v_big, 1'b0); check(tag, "chroma_bad", chroma_bad, 1'b0);
   endtask

   task automatic window(input int len, input int seed);
      for (int j = 0; j < len; j++) begin
         int y, c;
         case ((j + seed) % 6)
            0: begin y = 0;   c = 0;   end
            1: begin y = 15;  c = 127; end
            2: begin y = 16;  c = 128; end
            3: begin y = 17;  c = 129; end
            4: begin y = 255; c = 255; end
            default: begin y = (j * 37 + seed * 11) % 256; c = (j * 53 + seed) % 256; end
         endcase
         cyc(1'b1, y, c);
      end
   endtask

   task automatic gap(input int len);
      for (int j = 0; j < len; j++) cyc(1'b0, 3, 200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: outputs low while reset held
      all_low("R8");
      rst_n = 1'b1;
      cyc(1'b0, 0, 0);
      all_low("R8");
      gap(4);
      // R4: a 19-clock window gives no command
      moves = 0;
      window(MIN_WIN - 1, 0);
      gap(2);
      check("R4", "short_window_moves", moves != 0, 1'b0);
      // R3: window closed with far-off codes: idle
      cyc(1'b0, 0, 0);
      all_low("R3");
      // precharge windows, varied lengths and start phases
      for (int k = 0; k < 11; k++) begin
         window((k == 3) ? MIN_WIN : MIN_WIN + 3 + (k % 4), k);
         gap(3 + (k % 2));
      end
      // R4: exactly MIN_WIN-long window still corrects on its last clock
      moves = 0;
      window(MIN_WIN, 2);
      gap(2);
      check("R4", "min_window_moves", moves != 0, 1'b1);
      // R7: precharge must be over now
      check("R7", "precharge_finished", pre == PRE_WINS, 1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule